// File: doc/BRIEF.md
# Memory-Mapped GPIO Bus Slave

This block sits on a processor's external asynchronous memory bus and exposes a small byte-wide register map. The processor reaches it through an address bus, a shared 8-bit data bus, an active-low select and a read/not-write line. A bank of bidirectional pins sits on the other side. Software reads the pins' live levels at the bottom of the map. It reads a constant six-byte identification string from a fixed window, so it can recognise the device before using it. Writes to the top of the map load a direction byte and a drive byte for each group of eight pins, and these two registers steer the pin tristate buffers.

The bus lines are sampled on the system clock by a three-state bus controller. The states are `BS_IDLE` (not selected), `BS_RD` (selected, reading) and `BS_WR` (selected, writing). The transitions are:
- idle-to-read: select low with read/not-write high.
- idle-to-write: select low with read/not-write low. This one loads a register.
- read-to-write: read/not-write falls while the block stays selected. This one also loads a register.
- write-to-read: read/not-write rises while the block stays selected.
- any-to-idle: the select goes high.

Only a transition into `BS_WR` produces a register write, so one bus write loads at most one byte. The data bus is driven only while the processor reads the block. At all other times the block releases it.

Top module: `gpio_bus_slave`

## Requirements
- R1: A read of address k, for k from 0 to PIN_BYTES-1, returns the synchronized levels of pins 8k+7 down to 8k, with pin 8k in bit 0.
- R2: Reads of addresses 10 to 15 return the bytes 0xC0, 0x01, 0xBE, 0xEF, 0x00 and 0x00, in that order.
- R3: A read of any other address returns 0x00. This includes the write-only addresses 16 to 19.
- R4: A write to address 16+k loads direction byte k, and a write to address 18+k loads drive byte k. Bit i of either byte controls pin 8k+i.
- R5: A pin whose direction bit is 1 carries its drive bit. A pin whose direction bit is 0 is released, and the level an external source puts on it is read back.
- R6: After reset all direction and drive bits are 0, so every pin is released.
- R7: A change on a pin shows in the readback after exactly two rising clock edges. After one edge the readback still holds the old level.
- R8: A write is captured on the first clock edge of a write select. Data changes while the same select is held have no effect.
- R9: Writes to the pin, signature or unmapped addresses change neither the direction and drive registers nor the signature.
- R10: The data bus is driven only while the select is low and read/not-write is high. When the select is high, the controller is in `BS_IDLE` from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus lines and pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (5) | Byte address from the processor |
| bus_data | inout | 8 | Shared data bus |
| bus_cs_n | input | 1 | Active-low select |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| gpio_pad | inout | 8*PIN_BYTES (16) | External bidirectional pins |

## Verification
The bench builds the block with its defaults: two pin bytes and a 5-bit address. With two pin bytes, both direction/drive lanes can be tested. This shows that a write to one lane leaves the other untouched, and lets the bench mix driven and released pins inside one byte. The 5-bit address space covers the whole map plus unmapped addresses on both sides of the signature window and at the very top. The scoreboard pairs each read with its expected byte, which catches decode slips between neighbouring addresses.

// File: rtl/gpio_bus_pkg.sv
package gpio_bus_pkg;

    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_RD   = 2'd1,
        BS_WR   = 2'd2
    } bus_state_e;

    localparam int unsigned ID_LEN = 6;

    function automatic logic [7:0] id_byte(input int unsigned idx);
        logic [7:0] b;
        case (idx)
            0:       b = 8'hC0;
            1:       b = 8'h01;
            2:       b = 8'hBE;
            3:       b = 8'hEF;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= pin_in;
            stable_q <= meta_q;
        end
    end

    assign pin_out = stable_q;

    // Readback lags the pins by exactly two edges
    assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (pin_out == $past(pin_in, 2)));

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
    parameter int unsigned NBYTE    = 2,
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned DIR_BASE = 16,
    parameter int unsigned DRV_BASE = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [7:0]           wr_data,
    output logic [8*NBYTE-1:0]   dir_q,
    output logic [8*NBYTE-1:0]   drv_q
);

    localparam int unsigned NPIN = 8 * NBYTE;

    logic [31:0] addr_w;
    assign addr_w = 32'(wr_addr);

    logic [7:0] dir_lane [NBYTE];
    logic [7:0] drv_lane [NBYTE];

    for (genvar k = 0; k < NBYTE; k++) begin : g_lane
        logic dir_hit;
        logic drv_hit;
        assign dir_hit = wr_en && (addr_w == DIR_BASE + k);
        assign drv_hit = wr_en && (addr_w == DRV_BASE + k);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dir_lane[k] <= 8'h00;
            end else if (dir_hit) begin
                dir_lane[k] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                drv_lane[k] <= 8'h00;
            end else if (drv_hit) begin
                drv_lane[k] <= wr_data;
            end
        end

        assign dir_q[8*k +: 8] = dir_lane[k];
        assign drv_q[8*k +: 8] = drv_lane[k];
    end

    // Without a write strobe neither register may move
    assert_regs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dir_q) && $stable(drv_q)));

    // A strobe aimed outside both register windows leaves them alone
    assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr_w < DIR_BASE || addr_w >= DRV_BASE + NBYTE))
        |=> ($stable(dir_q) && $stable(drv_q)));

    logic unused_npin;
    assign unused_npin = (NPIN == 0);

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_bus_pkg::*;
#(
    parameter int unsigned NBYTE    = 2,
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned SIG_BASE = 10
) (
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [8*NBYTE-1:0] pin_lvl,
    output logic [7:0]         rd_data
);

    logic [31:0] a;
    assign a = 32'(rd_addr);

    always_comb begin
        rd_data = 8'h00;
        if (a < NBYTE) begin
            for (int k = 0; k < int'(NBYTE); k++) begin
                if (a == 32'(k)) rd_data = pin_lvl[8*k +: 8];
            end
        end else if (a >= SIG_BASE && a < SIG_BASE + ID_LEN) begin
            rd_data = id_byte(a - SIG_BASE);
        end
    end

endmodule

// File: rtl/gpio_bus_slave.sv
module gpio_bus_slave
    import gpio_bus_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned PIN_BYTES = 2,
    parameter int unsigned SIG_BASE  = 10,
    parameter int unsigned DIR_BASE  = 16,
    parameter int unsigned DRV_BASE  = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    inout  wire  [7:0]               bus_data,
    input  logic                     bus_cs_n,
    input  logic                     bus_rnw,
    inout  wire  [8*PIN_BYTES-1:0]   gpio_pad
);

    localparam int unsigned NPIN = 8 * PIN_BYTES;

    bus_state_e state_q;
    bus_state_e state_d;
    logic       wr_pulse;
    logic       bus_oe;

    logic [NPIN-1:0] pin_lvl;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] drv_q;
    logic [7:0]      rd_data;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE: begin
                if (!bus_cs_n) state_d = bus_rnw ? BS_RD : BS_WR;
            end
            BS_RD: begin
                if (bus_cs_n)      state_d = BS_IDLE;
                else if (!bus_rnw) state_d = BS_WR;
            end
            BS_WR: begin
                if (bus_cs_n)      state_d = BS_IDLE;
                else if (bus_rnw)  state_d = BS_RD;
            end
            default: state_d = BS_IDLE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        wr_pulse = (state_d == BS_WR) && (state_q != BS_WR);
        bus_oe   = !bus_cs_n && bus_rnw;
    end

    gpio_pin_sync #(
        .WIDTH (NPIN)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (gpio_pad),
        .pin_out (pin_lvl)
    );

    gpio_ctrl_regs #(
        .NBYTE    (PIN_BYTES),
        .ADDR_W   (ADDR_W),
        .DIR_BASE (DIR_BASE),
        .DRV_BASE (DRV_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_pulse),
        .wr_addr (bus_addr),
        .wr_data (bus_data),
        .dir_q   (dir_q),
        .drv_q   (drv_q)
    );

    gpio_read_mux #(
        .NBYTE    (PIN_BYTES),
        .ADDR_W   (ADDR_W),
        .SIG_BASE (SIG_BASE)
    ) u_rmux (
        .rd_addr (bus_addr),
        .pin_lvl (pin_lvl),
        .rd_data (rd_data)
    );

    assign bus_data = bus_oe ? rd_data : 8'hzz;

    for (genvar i = 0; i < NPIN; i++) begin : g_pad
        assign gpio_pad[i] = dir_q[i] ? drv_q[i] : 1'bz;
    end

    // A held write select loads nothing after its first edge
    assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_WR && !bus_cs_n && !bus_rnw)
        |=> ($stable(dir_q) && $stable(drv_q)));

    // Deselect always returns the controller to idle
    assert_deselect_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cs_n |=> (state_q == BS_IDLE));

    // The read state is only held while a read is on the bus
    assert_read_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_RD) |-> $past(!bus_cs_n && bus_rnw));

endmodule

// File: tb/gpio_bus_slave_tb.sv
`timescale 1ns/1ps
module gpio_bus_slave_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        cs_n = 1'b1;
    logic        rnw = 1'b1;
    logic        tb_drv = 1'b0;
    logic [7:0]  tb_dat = '0;
    logic [15:0] frc_en = '0;
    logic [15:0] frc_val = '0;

    wire  [7:0]  bus_data;
    wire  [15:0] gpio_pad;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      req_q[$];
    event       smp_ev;
    event       done_ev;

    always #4 clk = ~clk;

    assign bus_data = tb_drv ? tb_dat : 8'hzz;
    for (genvar i = 0; i < 16; i++) begin : g_frc
        assign gpio_pad[i] = frc_en[i] ? frc_val[i] : 1'bz;
    end

    gpio_bus_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (addr),
        .bus_data (bus_data),
        .bus_cs_n (cs_n),
        .bus_rnw  (rnw),
        .gpio_pad (gpio_pad)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected byte when a read is at its sample point
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() != 0) begin
                chk(req_q.pop_front(), "read", {24'h0, bus_data}, {24'h0, exp_q.pop_front()});
            end
            -> done_ev;
        end
    end

    // Driver: one read cycle; pushes its expectation for the monitor
    task automatic bus_read(input logic [4:0] a, input logic [7:0] e, input string req);
        exp_q.push_back(e);
        req_q.push_back(req);
        @(negedge clk);
        cs_n = 1'b0; rnw = 1'b1; addr = a; tb_drv = 1'b0;
        @(negedge clk);
        #1;
        -> smp_ev;
        @(done_ev);
        cs_n = 1'b1;
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d,
                             input bit late_change, input logic [7:0] d2);
        @(negedge clk);
        cs_n = 1'b0; rnw = 1'b0; addr = a; tb_drv = 1'b1; tb_dat = d;
        @(negedge clk);
        if (late_change) tb_dat = d2;
        @(negedge clk);
        cs_n = 1'b1; tb_drv = 1'b0; rnw = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        // R6: reset state, all pins released
        frc_en = 16'hFFFF; frc_val = 16'h3CA5;
        idle(4);
        rst_n = 1'b1;
        idle(3);
        chk("R6", "pads after reset", {16'h0, gpio_pad}, 32'h3CA5);
        bus_read(5'd0, 8'hA5, "R6");
        bus_read(5'd1, 8'h3C, "R1");

        // R2: identification window
        bus_read(5'd10, 8'hC0, "R2");
        bus_read(5'd11, 8'h01, "R2");
        bus_read(5'd12, 8'hBE, "R2");
        bus_read(5'd13, 8'hEF, "R2");
        bus_read(5'd14, 8'h00, "R2");
        bus_read(5'd15, 8'h00, "R2");

        // R3: unmapped and write-only reads
        bus_read(5'd2,  8'h00, "R3");
        bus_read(5'd9,  8'h00, "R3");
        bus_read(5'd16, 8'h00, "R3");
        bus_read(5'd19, 8'h00, "R3");
        bus_read(5'd31, 8'h00, "R3");

        // R4/R5: low nibble of byte 0 driven, rest forced by bench
        frc_en = 16'hFFF0; frc_val = 16'h9B70;
        bus_write(5'd16, 8'h0F, 1'b0, 8'h00);
        bus_write(5'd18, 8'h0A, 1'b0, 8'h00);
        idle(3);
        chk("R4", "byte0 driven nibble", {28'h0, gpio_pad[3:0]}, 32'hA);
        bus_read(5'd0, 8'h7A, "R5");
        bus_read(5'd1, 8'h9B, "R5");

        // R4: second lane, high nibble of byte 1 driven
        frc_en = 16'h0FF0;
        bus_write(5'd17, 8'hF0, 1'b0, 8'h00);
        bus_write(5'd19, 8'h50, 1'b0, 8'h00);
        idle(3);
        chk("R4", "byte1 driven nibble", {28'h0, gpio_pad[15:12]}, 32'h5);
        bus_read(5'd1, 8'h5B, "R4");
        bus_read(5'd0, 8'h7A, "R4");

        // R9: writes to non-register addresses are ignored
        bus_write(5'd10, 8'hFF, 1'b0, 8'h00);
        bus_write(5'd0,  8'hFF, 1'b0, 8'h00);
        bus_write(5'd31, 8'hFF, 1'b0, 8'h00);
        bus_write(5'd12, 8'h00, 1'b0, 8'h00);
        idle(3);
        bus_read(5'd10, 8'hC0, "R9");
        bus_read(5'd12, 8'hBE, "R9");
        chk("R9", "byte0 nibble kept", {28'h0, gpio_pad[3:0]}, 32'hA);
        chk("R9", "byte1 nibble kept", {28'h0, gpio_pad[15:12]}, 32'h5);
        bus_read(5'd0, 8'h7A, "R9");

        // R8: data change during a held write select is ignored
        bus_write(5'd18, 8'h05, 1'b1, 8'h0F);
        idle(3);
        chk("R8", "first-edge capture", {28'h0, gpio_pad[3:0]}, 32'h5);
        bus_read(5'd0, 8'h75, "R8");

        // R5: release all pins again and read forced levels
        bus_write(5'd16, 8'h00, 1'b0, 8'h00);
        bus_write(5'd17, 8'h00, 1'b0, 8'h00);
        frc_en = 16'hFFFF; frc_val = 16'h1234;
        idle(3);
        chk("R5", "released pads", {16'h0, gpio_pad}, 32'h1234);
        bus_read(5'd0, 8'h34, "R5");
        bus_read(5'd1, 8'h12, "R5");

        // R7: two-edge synchronizer latency
        frc_val = 16'h0011;
        idle(3);
        @(negedge clk);
        frc_val = 16'h00EE;
        cs_n = 1'b0; rnw = 1'b1; addr = 5'd0;
        @(negedge clk);
        #1;
        chk("R7", "after one edge", {24'h0, bus_data}, 32'h11);
        @(negedge clk);
        #1;
        chk("R7", "after two edges", {24'h0, bus_data}, 32'hEE);
        cs_n = 1'b1;

        // R10: bus released while not selected
        @(negedge clk);
        tb_drv = 1'b1; tb_dat = 8'h5A; rnw = 1'b1;
        #1;
        chk("R10", "idle bus", {24'h0, bus_data}, 32'h5A);
        @(negedge clk);
        rnw = 1'b0;
        #1;
        chk("R10", "idle bus rnw low", {24'h0, bus_data}, 32'h5A);
        tb_drv = 1'b0; rnw = 1'b1;
        idle(2);

        finish_run();
    end

endmodule